// File: doc/BRIEF.md
# Dual-Host Secondary Interrupt Controller

This block collects up to 24 interrupt sources and presents them to two independent hosts. Each source is synchronized and then passed through an edge detector. A shared per-source selector chooses rising edges, falling edges, both edges or neither. Every detected event is latched into a status bit on both host lines. Each host owns its own status bytes and mask bytes, and has its own active-low interrupt output. That output is low while any of the host's status bits is set and unmasked.

Software reaches the block through a byte-wide synchronous register port. The port has an address, write data, a write strobe, a read strobe and registered read data. A control bit selects how status is cleared: by writing 1s to a status byte, or as a side effect of reading it. A second event that arrives while a status bit is still pending is held in a one-deep buffer, so draining a busy source takes two clears. A test-set register forces status bits on both lines without toggling real inputs.

The register map uses 5-bit byte addresses:
- control at 0x00, with bit 0 as the clear-on-read bit;
- test-set at 0x04–0x06;
- edge selectors at 0x08–0x0D;
- line 0 status at 0x10–0x12 and line 0 mask at 0x14–0x16;
- line 1 status at 0x18–0x1A and line 1 mask at 0x1C–0x1E.

In the status, mask and test-set bytes, source i is bit i mod 8 of byte i/8.

Top module: `dual_host_irqc`

## Requirements
- R1: After reset, every status bit is 0, every mask bit of both lines is 1, the edge selectors and the control byte are 0, and both interrupt outputs are high.
- R2: Source i is configured by the two bits at offset 2*(i mod 4) of edge byte i/4 (address 0x08 + i/4). The upper bit of the pair enables rising-edge detection and the lower bit enables falling-edge detection; with both bits set, either edge is detected.
- R3: A source whose two selector bits are both 0 never sets a status bit, whatever its input does.
- R4: An input change applied before clock edge k sets the status bit at edge k+2: two synchronizer stages, then detection against the previous synchronized value. The interrupt output follows combinationally from the registers.
- R5: One event sets the same status bit on both lines. Host line L drives host_irq_n[L] low exactly while (status AND NOT mask) of line L is nonzero.
- R6: A mask bit of 1 keeps its source from driving the line's interrupt output. Each line has its own writable mask bytes.
- R7: With control bit 0 clear, writing a 1 to a status bit clears it, writing 0 has no effect, and reading does not clear.
- R8: With control bit 0 set, a read of a status byte returns the bits and clears exactly those returned bits. Writes to status bytes are ignored.
- R9: A second event on a source whose status bit is set is buffered. The first clear leaves the bit set, and a second clear empties it.
- R10: An event and a clear that hit the same status bit in the same cycle leave the bit set.
- R11: Writing 1s to a test-set byte sets the matching status bits on both lines at once. The test-set bytes read as 0.
- R12: The control and edge bytes read back as written. Read data appears on the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | NUM_SRC | Raw interrupt sources, asynchronous |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| host_irq_n | output | 2 | Active-low interrupt per host line |

## Verification
A source edge reaches the status register two clock edges after the edge that first samples it. The bench therefore drives sources just after a falling clock edge, and checks the interrupt pin one cycle before and again at the cycle the bit is due. A bus write takes effect at the next rising edge, and read data is registered on the strobe edge. Every read task samples at the falling edge after that rising edge. For the same-cycle event-versus-clear case, the clear write is timed by hand so that its strobe meets the detection edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] ADR_CTRL      = 5'h00;
  localparam logic [ADDR_W-1:0] ADR_TEST      = 5'h04;
  localparam logic [ADDR_W-1:0] ADR_EDGE      = 5'h08;
  localparam logic [ADDR_W-1:0] ADR_STAT_BASE = 5'h10;
  localparam logic [ADDR_W-1:0] ADR_MASK_BASE = 5'h14;
  localparam int LINE_STRIDE = 8;
  localparam int NUM_LINES = 2;

  function automatic int bytes_for(input int bits);
    return (bits + 7) / 8;
  endfunction

  // sel[1] selects rising, sel[0] selects falling
  function automatic logic edge_fire(input logic cur, input logic prev,
                                     input logic [1:0] sel);
    return (sel[1] & cur & ~prev) | (sel[0] & ~cur & prev);
  endfunction

  // returns {status_next, pending_next}; a new event always survives a clear
  function automatic logic [1:0] next_state(input logic st, input logic pend,
                                            input logic evt, input logic clr);
    if (st && clr)  return {pend | evt, pend & evt};
    else if (st)    return {1'b1, pend | evt};
    else            return {evt, 1'b0};
  endfunction
endpackage

// File: rtl/irqc_edge_detect.sv
module irqc_edge_detect #(
  parameter int N = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   src,
  input  logic [2*N-1:0] cfg,
  output logic [N-1:0]   evt
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
        prev_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= src[i];
        sync_q[i] <= meta_q[i];
        prev_q[i] <= sync_q[i];
      end
    end
    assign evt[i] = irqc_pkg::edge_fire(sync_q[i], prev_q[i], cfg[2*i +: 2]);
  end

  assert_no_event_without_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q == prev_q) |-> (evt == '0));
  assert_disabled_sources_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == '0) |-> (evt == '0));
endmodule

// File: rtl/irqc_host_bank.sv
module irqc_host_bank #(
  parameter int N  = 24,
  parameter int NB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  evt,
  input  logic [N-1:0]  clr,
  input  logic [NB-1:0] mask_we,
  input  logic [7:0]    wdata,
  output logic [N-1:0]  status,
  output logic [N-1:0]  pending,
  output logic [N-1:0]  mask,
  output logic          irq_n
);
  logic [N-1:0] st_q, pend_q, mask_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [1:0] nxt;
    assign nxt = irqc_pkg::next_state(st_q[i], pend_q[i], evt[i], clr[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[i]   <= 1'b0;
        pend_q[i] <= 1'b0;
        mask_q[i] <= 1'b1;
      end else begin
        st_q[i]   <= nxt[1];
        pend_q[i] <= nxt[0];
        if (mask_we[i/8]) mask_q[i] <= wdata[i%8];
      end
    end
  end

  assign status  = st_q;
  assign pending = pend_q;
  assign mask    = mask_q;
  assign irq_n   = ~|(st_q & ~mask_q);

  assert_reset_masks_all_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (mask == '1 && irq_n));
  assert_pending_implies_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~st_q) == '0));
  assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & $past(evt)) == $past(evt)));
  assert_buffered_reasserts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & $past(clr & pend_q)) == $past(clr & pend_q)));
  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & $past(clr & ~pend_q & ~evt)) == '0));
endmodule

// File: rtl/dual_host_irqc.sv
module dual_host_irqc #(
  parameter int NUM_SRC = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [4:0]         bus_addr,
  input  logic [7:0]         bus_wdata,
  input  logic               bus_we,
  input  logic               bus_re,
  output logic [7:0]         bus_rdata,
  output logic [1:0]         host_irq_n
);
  import irqc_pkg::*;

  localparam int NB = bytes_for(NUM_SRC);
  localparam int EB = bytes_for(2 * NUM_SRC);
  localparam int SB = NB * 8;
  localparam int EW = EB * 8;

  logic              ctrl_cor;
  logic [EW-1:0]     cfg_q;
  logic [NUM_SRC-1:0] evt_src, test_set, evt_all;
  logic [NUM_SRC-1:0] st_v   [NUM_LINES];
  logic [NUM_SRC-1:0] pend_v [NUM_LINES];
  logic [NUM_SRC-1:0] mask_v [NUM_LINES];
  logic [NUM_SRC-1:0] clr_v  [NUM_LINES];
  logic [NB-1:0]      stat_hit [NUM_LINES];
  logic [NB-1:0]      mask_we  [NUM_LINES];
  logic [7:0]         rd_mux;

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_cor <= 1'b0;
      cfg_q    <= '0;
    end else if (bus_we) begin
      if (bus_addr == ADR_CTRL) ctrl_cor <= bus_wdata[0];
      for (int b = 0; b < EB; b++)
        if (bus_addr == 5'(ADR_EDGE + b)) cfg_q[8*b +: 8] <= bus_wdata;
    end
  end

  irqc_edge_detect #(.N(NUM_SRC)) u_edge (
    .clk (clk),
    .rst_n (rst_n),
    .src (src_in),
    .cfg (cfg_q[2*NUM_SRC-1:0]),
    .evt (evt_src)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_test
    assign test_set[i] = bus_we && (bus_addr == 5'(ADR_TEST + i/8)) && bus_wdata[i%8];
  end
  assign evt_all = evt_src | test_set;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    for (genvar b = 0; b < NB; b++) begin : g_byte
      assign stat_hit[l][b] = (bus_addr == 5'(ADR_STAT_BASE + LINE_STRIDE*l + b));
      assign mask_we[l][b]  = bus_we && (bus_addr == 5'(ADR_MASK_BASE + LINE_STRIDE*l + b));
    end
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
      assign clr_v[l][i] = stat_hit[l][i/8] &&
        ((bus_we && !ctrl_cor && bus_wdata[i%8]) || (bus_re && ctrl_cor && st_v[l][i]));
    end
    irqc_host_bank #(.N(NUM_SRC), .NB(NB)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt_all),
      .clr     (clr_v[l]),
      .mask_we (mask_we[l]),
      .wdata   (bus_wdata),
      .status  (st_v[l]),
      .pending (pend_v[l]),
      .mask    (mask_v[l]),
      .irq_n   (host_irq_n[l])
    );
  end

  // read path
  always_comb begin
    logic [SB-1:0] st_pad, mk_pad;
    rd_mux = '0;
    if (bus_addr == ADR_CTRL) rd_mux = {7'b0, ctrl_cor};
    for (int b = 0; b < EB; b++)
      if (bus_addr == 5'(ADR_EDGE + b)) rd_mux = cfg_q[8*b +: 8];
    for (int l = 0; l < NUM_LINES; l++) begin
      st_pad = SB'(st_v[l]);
      mk_pad = ~SB'(~mask_v[l]);
      for (int b = 0; b < NB; b++) begin
        if (bus_addr == 5'(ADR_STAT_BASE + LINE_STRIDE*l + b)) rd_mux = st_pad[8*b +: 8];
        if (bus_addr == 5'(ADR_MASK_BASE + LINE_STRIDE*l + b)) rd_mux = mk_pad[8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  assert_test_sets_both_lines_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_v[0] & st_v[1] & $past(test_set)) == $past(test_set)));
  assert_cor_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && ctrl_cor && bus_addr == ADR_STAT_BASE) |=>
      ((st_v[0][7:0] & $past(st_v[0][7:0] & ~pend_v[0][7:0] & ~evt_all[7:0])) == '0));
  assert_write_ignored_in_cor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && ctrl_cor) |=> ((st_v[0] & $past(st_v[0])) == $past(st_v[0])));
endmodule

// File: tb/tb_dual_host_irqc.sv
module tb_dual_host_irqc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] src = '0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  rdata;
  logic [1:0]  irq_n;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_host_irqc #(.NUM_SRC(24)) dut (
    .clk(clk), .rst_n(rst_n), .src_in(src), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_re(re), .bus_rdata(rdata), .host_irq_n(irq_n));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic rdchk(input string tag, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic settle(); repeat (4) @(negedge clk); endtask

  task automatic t_reset();
    chk("R1 irq_n", {6'b0, irq_n}, 8'h03);
    for (int b = 0; b < 3; b++) begin
      rdchk("R1 mask0", 5'(8'h14 + b), 8'hFF);
      rdchk("R1 mask1", 5'(8'h1C + b), 8'hFF);
      rdchk("R1 stat0", 5'(8'h10 + b), 8'h00);
    end
    rdchk("R1 ctrl", 5'h00, 8'h00);
    rdchk("R1 edge", 5'h0D, 8'h00);
  endtask

  task automatic t_regs();
    wr(5'h0A, 8'h5A);
    rdchk("R12 edge readback", 5'h0A, 8'h5A);
    wr(5'h0A, 8'h00);
    rdchk("R11 test reads zero", 5'h04, 8'h00);
  endtask

  task automatic t_disabled();
    src[1] = 1'b1; settle(); src[1] = 1'b0; settle();
    rdchk("R3 no status", 5'h10, 8'h00);
  endtask

  task automatic t_rise_latency();
    wr(5'h08, 8'h02);              // source 0 rising
    wr(5'h14, 8'hFE);              // unmask source 0 on line 0
    chk("R6 masked line high", {7'b0, irq_n[0]}, 8'h01);
    @(negedge clk); src[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R4 not yet", {7'b0, irq_n[0]}, 8'h01);
    @(negedge clk);
    chk("R4 due", {7'b0, irq_n[0]}, 8'h00);
    chk("R5 line1 masked", {7'b0, irq_n[1]}, 8'h01);
    rdchk("R5 line1 status", 5'h18, 8'h01);
    rdchk("R7 read keeps", 5'h10, 8'h01);
    wr(5'h10, 8'h00);
    rdchk("R7 zero write", 5'h10, 8'h01);
    wr(5'h10, 8'h01);
    chk("R7 cleared irq", {7'b0, irq_n[0]}, 8'h01);
    rdchk("R7 line1 untouched", 5'h18, 8'h01);
    wr(5'h18, 8'h01);
    src[0] = 1'b0; settle();
    rdchk("R2 rising only", 5'h10, 8'h00);
  endtask

  task automatic t_fall_both();
    wr(5'h09, 8'h04);              // source 5 falling
    wr(5'h0D, 8'h30);              // source 22 both edges
    src[5] = 1'b1; settle();
    rdchk("R2 fall-only ignores rise", 5'h10, 8'h00);
    src[5] = 1'b0; settle();
    rdchk("R2 fall", 5'h10, 8'h20);
    wr(5'h10, 8'h20); wr(5'h18, 8'h20);
    src[22] = 1'b1; settle();
    rdchk("R2 both rise", 5'h12, 8'h40);
    wr(5'h12, 8'h40); wr(5'h1A, 8'h40);
    src[22] = 1'b0; settle();
    rdchk("R2 both fall", 5'h12, 8'h40);
    wr(5'h12, 8'h40); wr(5'h1A, 8'h40);
    rdchk("R2 drained", 5'h12, 8'h00);
  endtask

  task automatic t_cor();
    wr(5'h00, 8'h01);
    wr(5'h04, 8'h08);
    rdchk("R11 line0 set", 5'h10, 8'h08);
    rdchk("R8 cleared by read", 5'h10, 8'h00);
    wr(5'h18, 8'hFF);
    rdchk("R8 write ignored", 5'h18, 8'h08);
    rdchk("R8 line1 cleared", 5'h18, 8'h00);
    wr(5'h00, 8'h00);
  endtask

  task automatic t_buffered();
    wr(5'h04, 8'h10); wr(5'h04, 8'h10);
    wr(5'h10, 8'h10);
    rdchk("R9 reasserted", 5'h10, 8'h10);
    wr(5'h10, 8'h10);
    rdchk("R9 drained", 5'h10, 8'h00);
    wr(5'h18, 8'h10); wr(5'h18, 8'h10);
  endtask

  task automatic t_collide();
    wr(5'h04, 8'h01);              // status bit 0 set, nothing pending
    @(negedge clk); src[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    addr = 5'h10; wdata = 8'h01; we = 1'b1;
    @(negedge clk); we = 1'b0;
    rdchk("R10 event beats clear", 5'h10, 8'h01);
    wr(5'h10, 8'h01);
    rdchk("R10 then clears", 5'h10, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_disabled();
    t_rise_latency();
    t_fall_both();
    t_cor();
    t_buffered();
    t_collide();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule